// File: doc/BRIEF.md
# Timer event flag register

This block holds the eight event flags of an advanced control timer. The timer core feeds it a small set of signals:

- the break input level and the trigger input;
- strobes for commutation and for update;
- per-channel capture strobes;
- the running counter with its direction, the reload value and the four compare values.

The block turns these into sticky flags. Software reads the flags over a byte-wide register bus and clears them by writing zeros. A masked OR of the flags drives a single interrupt request.

Each capture/compare channel has a configuration bit that selects input or output mode. In input mode, its flag follows capture strobes. The flag also drops when the core reports a read of that channel's capture low byte. In output mode, the flag comes from a counter match. In the center-aligned counting modes, that match is qualified by the counting direction. A compare value above the reload value is flagged at the top of the count.

Top module: `tim_evt_status`

## Requirements
- R1: The flag register sits at bus offset 5 and resets to 0x00. Its bits from 7 down to 0 are break, trigger, commutation, channel 4, channel 3, channel 2, channel 1 and update. A read at any other offset returns 0x00.
- R2: A write at offset 5 clears every flag whose data bit is 0. A flag whose data bit is 1 is kept unchanged.
- R3: The break flag is set in every cycle in which `brk_in` is high. A write of 0 has no effect on it while `brk_in` stays high.
- R4: With `trg_both` low, only a rising edge of `trg_in` sets the trigger flag. With `trg_both` high, both edges set it.
- R5: A pulse on `com_evt` sets the commutation flag. A pulse on `upd_evt` sets the update flag.
- R6: When `cms` is 0 (edge-aligned), a channel in output mode sets its flag on a `cnt_tick` cycle in which `cnt` equals that channel's compare value.
- R7: When `cms` is not 0 (center-aligned), an output-mode match counts only if the current direction is allowed. A count of 0 is treated as up, a count equal to `arr` is treated as down, and any other count follows `cnt_dn`. `cms` = 1 allows the down direction only, 2 allows up only, and 3 allows both.
- R8: In a center-aligned mode, an output-mode channel whose compare value is greater than `arr` sets its flag on a `cnt_tick` cycle with `cnt` equal to `arr`.
- R9: For a channel in input mode (`ch_in` bit = 1), its `cap_evt` bit sets the flag and counter matches are ignored. A `cap_lo_rd` pulse on that channel clears the flag. `cap_lo_rd` has no effect on a channel in output mode.
- R10: A hardware set and a clear in the same cycle leave the flag set.
- R11: `irq` is a registered OR of (flags AND `ie`). It rises one cycle after a flag and its enable bit are both high.
- R12: A read returns the flag values held before any set or clear that takes effect at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| brk_in | input | 1 | Break input, active high |
| trg_in | input | 1 | Trigger input level |
| trg_both | input | 1 | Flag both trigger edges |
| com_evt | input | 1 | Commutation update strobe |
| upd_evt | input | 1 | Update event strobe |
| ch_in | input | 4 | Channel mode, 1 = input capture |
| cap_evt | input | 4 | Polarity-matched capture strobes |
| cap_lo_rd | input | 4 | Capture low-byte read strobes |
| cnt_tick | input | 1 | Counter advanced to `cnt` this cycle |
| cnt_dn | input | 1 | Counter is counting down |
| cms | input | 2 | Alignment mode, 0 = edge-aligned |
| cnt | input | CW | Counter value |
| arr | input | CW | Reload value |
| ccr | input | 4*CW | Compare values, channel 1 in the low bits |
| ie | input | 8 | Interrupt enables, same layout as the flags |
| irq | output | 1 | Interrupt request, registered |

## Verification
The hardest cases to reach from the ports are the center-aligned compare flags at the two ends of the count. These are a compare of 0 at the bottom, a compare equal to the reload value at the top, and a compare above the reload value. Each depends on the direction convention and the alignment mode together. The bench sweeps every alignment mode against every compare value from 0 to one past a small reload value. Each sweep walks the counter through a whole up/down period, one tick at a time. After every tick it reads the flag, compares it with an arithmetically derived expectation, and clears it.

// File: rtl/tim_evt_status.sv
`timescale 1ns/1ps
module tim_evt_status #(
  parameter int CW = 8,
  parameter int AW = 3,
  parameter logic [AW-1:0] OFFS = 3'd5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic            brk_in,
  input  logic            trg_in,
  input  logic            trg_both,
  input  logic            com_evt,
  input  logic            upd_evt,
  input  logic [3:0]      ch_in,
  input  logic [3:0]      cap_evt,
  input  logic [3:0]      cap_lo_rd,
  input  logic            cnt_tick,
  input  logic            cnt_dn,
  input  logic [1:0]      cms,
  input  logic [CW-1:0]   cnt,
  input  logic [CW-1:0]   arr,
  input  logic [4*CW-1:0] ccr,
  input  logic [7:0]      ie,
  output logic            irq
);
  logic [7:0] flags, set_v, clr_v;
  logic [3:0] cc_set;
  logic       trg_q;

  wire hit    = bus_addr == OFFS;
  wire center = cms != 2'd0;
  wire at_top = cnt == arr;
  wire up     = (cnt == '0) || (!at_top && !cnt_dn);
  wire dir_ok = !center || (up ? cms[1] : cms[0]);
  wire trg_ev = trg_both ? (trg_in ^ trg_q) : (trg_in & ~trg_q);

  for (genvar i = 0; i < 4; i++) begin : g_ch
    wire [CW-1:0] cv = ccr[i*CW +: CW];
    wire match = cnt_tick && (((cnt == cv) && dir_ok) || (center && at_top && (cv > arr)));
    assign cc_set[i] = ch_in[i] ? cap_evt[i] : match;
  end

  assign set_v     = {brk_in, trg_ev, com_evt, cc_set, upd_evt};
  assign clr_v     = ((bus_wr && hit) ? ~bus_wdata : 8'h00) | {3'b000, cap_lo_rd & ch_in, 1'b0};
  assign bus_rdata = (bus_rd && hit) ? flags : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= 8'h00;
      trg_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      trg_q <= trg_in;
      irq   <= |(flags & ie);
    end

  AST_BRK_STICKS: assert property (@(posedge clk) disable iff (!rst_n) brk_in |=> flags[7]); // R3
  AST_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && bus_wdata == 8'hFF) |=> ((flags & $past(flags)) == $past(flags))); // R2
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n) upd_evt |=> flags[0]); // R10
  AST_CAP_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lo_rd[0] && ch_in[0] && !cap_evt[0]) |=> !flags[1]); // R9
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (irq == $past(|(flags & ie)))); // R11
endmodule

// File: tb/tb_tim_evt_status.sv
`timescale 1ns/1ps
module tb_tim_evt_status;
  localparam int CW = 8;
  localparam int ARR = 6;
  logic clk = 0, rst_n = 0;
  logic [2:0] bus_addr = 3'd5;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic brk_in = 0, trg_in = 0, trg_both = 0, com_evt = 0, upd_evt = 0;
  logic [3:0] ch_in = 0, cap_evt = 0, cap_lo_rd = 0;
  logic cnt_tick = 0, cnt_dn = 0;
  logic [1:0] cms = 0;
  logic [CW-1:0] cnt = 0, arr = ARR;
  logic [4*CW-1:0] ccr = '1;
  logic [7:0] ie = 0;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  tim_evt_status dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc; @(posedge clk); #1; endtask

  task automatic rd(output logic [7:0] v);
    bus_addr = 3'd5; bus_rd = 1; #1; v = bus_rdata; bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    bus_addr = 3'd5; bus_wr = 1; bus_wdata = v; cyc; bus_wr = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - bad, total);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end

  initial begin
    logic [7:0] v;
    cyc; cyc; rst_n = 1; cyc;
    rd(v); chk("R1 reset", v, 8'h00);
    bus_addr = 3'd4; bus_rd = 1; #1; chk("R1 other offset", bus_rdata, 8'h00); bus_rd = 0;

    ch_in = 4'hF; upd_evt = 1; com_evt = 1; cap_evt = 4'hF; trg_in = 1; cyc;
    upd_evt = 0; com_evt = 0; cap_evt = 0; cyc;
    rd(v); chk("R1 R5 layout", v, 8'h7F);
    wr(8'hAA); rd(v); chk("R2 mixed clear", v, 8'h2A);
    wr(8'h00); rd(v); chk("R2 clear all", v, 8'h00);

    trg_in = 0; cyc; rd(v); chk("R4 falling ignored", v, 8'h00);
    trg_in = 1; cyc; rd(v); chk("R4 rising", v, 8'h40); wr(8'h00);
    trg_both = 1; trg_in = 0; cyc; rd(v); chk("R4 both falling", v, 8'h40); wr(8'h00);
    trg_both = 0;

    brk_in = 1; cyc; rd(v); chk("R3 set", v, 8'h80);
    wr(8'h00); rd(v); chk("R3 clear blocked", v, 8'h80);
    brk_in = 0; wr(8'h00); rd(v); chk("R3 clear after release", v, 8'h00);

    ch_in = 4'h1; cap_evt = 4'h1; cyc; cap_evt = 0;
    rd(v); chk("R9 capture set", v, 8'h02);
    cap_lo_rd = 4'h1; cyc; cap_lo_rd = 0; rd(v); chk("R9 low read clears", v, 8'h00);
    ccr[CW-1:0] = 8'd3; cnt = 3; cnt_tick = 1; cyc; cnt_tick = 0;
    rd(v); chk("R9 match ignored", v, 8'h00);
    ch_in = 4'h0; cnt_tick = 1; cyc; cnt_tick = 0;
    rd(v); chk("R6 match out mode", v, 8'h02);
    cap_lo_rd = 4'h1; cyc; cap_lo_rd = 0; rd(v); chk("R9 low read no effect on output", v, 8'h02);
    wr(8'h00); ccr = '1;

    upd_evt = 1; bus_wr = 1; bus_wdata = 8'h00;
    bus_rd = 1; #1; chk("R12 read before update", bus_rdata, 8'h00); bus_rd = 0;
    cyc; bus_wr = 0; upd_evt = 0;
    rd(v); chk("R10 set wins", v, 8'h01);
    bus_wr = 1; bus_wdata = 8'h00; bus_rd = 1; #1;
    chk("R12 read before clear", bus_rdata, 8'h01); bus_rd = 0; cyc; bus_wr = 0;

    ie = 8'h20; com_evt = 1; cyc; com_evt = 0;
    chk("R11 irq lags", {7'd0, irq}, 8'h00);
    cyc; chk("R11 irq up", {7'd0, irq}, 8'h01);
    wr(8'h00); cyc; chk("R11 irq down", {7'd0, irq}, 8'h00);
    ie = 0;

    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c <= ARR + 1; c++) begin
        cms = m[1:0]; ccr[CW-1:0] = c[CW-1:0];
        for (int s = 0; s < (m == 0 ? ARR + 1 : 2 * ARR); s++) begin
          int cv; bit dn, up, e;
          if (m == 0) begin cv = s; dn = 0; end
          else if (s < ARR) begin cv = s; dn = 0; end
          else begin cv = 2 * ARR - s; dn = 1; end
          up = (cv == 0) || (cv != ARR && !dn);
          if (m == 0) e = (cv == c);
          else e = ((cv == c) && (up ? m[1] : m[0])) || (c > ARR && cv == ARR);
          cnt = cv[CW-1:0]; cnt_dn = dn; cnt_tick = 1; cyc; cnt_tick = 0;
          rd(v);
          chk(m == 0 ? "R6 sweep" : (c > ARR ? "R8 sweep" : "R7 sweep"), {7'd0, v[1]}, {7'd0, e});
          wr(8'hFD);
        end
      end
    end
    finish_run;
  end
endmodule